// File: doc/BRIEF.md
# Fully Associative Translation Cache with One-Bit-History Replacement

This block holds recently used logical-to-physical page translations in a small, fully associative table. Each entry keeps a 28-bit tag and a 24-bit physical page number. In the tag, bit 27 is the valid flag, bits 26..24 hold the 3-bit access function code, and bits 23..0 hold logical address bits 31..8. A lookup presents a function code, a 32-bit logical address and a page-size setting. One clock later the block returns hit or miss and the translated physical address.

New translations arrive on a load port. The slot for a new translation is chosen in this order: an entry already holding the same translation, then the lowest free slot, then a victim picked from one history bit per entry. Entries can be removed in three ways: a global flush, a selective flush that matches on function code and page, or a configuration write whose keep flag is clear.

A flush and a load in the same cycle are applied flush first. A lookup always sees the table as it stood before that cycle's updates.

Top module: `xlc_top`

## Requirements
- R1: `rsp_hit` and `rsp_paddr` are registered. They reflect the lookup presented one cycle earlier. After reset, and for any cycle where `lk_valid` was low or the lookup missed, both are zero.
- R2: A lookup hits only on a valid entry whose function code equals `lk_fc` and whose stored page matches `lk_addr[31:8]` under the page mask. When several entries match, the lowest index wins.
- R3: `pg_shift` gives log2 of the page size, from 8 to 15; values below 8 act as 8. The low `pg_shift-8` bits of the stored page and of the presented page are ignored in every compare. The physical address takes bits above `pg_shift` from the entry's page and bits below it from `lk_addr`.
- R4: A load that matches no valid entry writes the lowest-index invalid entry, if one exists.
- R5: Each entry has one history bit. A load, or a lookup hit on an entry that stays valid, sets that entry's bit. If that would set every bit, all other bits are cleared. With every entry valid, a non-matching load replaces the lowest-index entry whose bit is clear.
- R6: A load whose function code and masked page match valid entries invalidates all of them. It then writes the new translation into the lowest-index one, so no duplicate remains.
- R7: `fl_all`, or `cfg_wr` with `cfg_keep` low, invalidates every entry. `cfg_wr` with `cfg_keep` high leaves the table unchanged.
- R8: `fl_sel` invalidates exactly the valid entries whose function code equals `fl_fc` and whose masked page matches `fl_page`.
- R9: In one cycle, flushes apply before a load. The load then fills a freshly freed slot and survives. A lookup in that same cycle answers from the table before either update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_fc | input | 3 | Lookup function code |
| lk_addr | input | 32 | Lookup logical address |
| pg_shift | input | 4 | log2 of page size (8..15) |
| ld_en | input | 1 | Load a translation |
| ld_fc | input | 3 | Load function code |
| ld_page | input | 24 | Load logical page (address bits 31..8) |
| ld_ppage | input | 24 | Load physical page (address bits 31..8) |
| fl_all | input | 1 | Invalidate all entries |
| fl_sel | input | 1 | Selective invalidate |
| fl_fc | input | 3 | Selective flush function code |
| fl_page | input | 24 | Selective flush logical page |
| cfg_wr | input | 1 | Translation configuration write |
| cfg_keep | input | 1 | Keep table on configuration write |
| rsp_hit | output | 1 | Registered hit |
| rsp_paddr | output | 32 | Registered physical address, zero on miss |

## Verification
The table is first filled in order. This shows that free slots go first and that the saturation rule of the history bits holds. Lookups that repeat a page with a different function code, or under wider and narrower page masks, separate the function-code match from the masked-page match. Reloading a resident page, flushing one page and refilling, and combining a flush with a load and a lookup in one cycle each pin down one rule of update order. A long random run then mixes all operations over a small address space, to force frequent aliasing and eviction.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  localparam int FC_W     = 3;
  localparam int LA_W     = 32;
  localparam int PAGE_MIN = 8;
  localparam int TAG_AW   = LA_W - PAGE_MIN;
  localparam int SH_W     = 4;

  typedef struct packed {
    logic              v;
    logic [FC_W-1:0]   fc;
    logic [TAG_AW-1:0] la;
  } xlc_tag_t;

  function automatic logic [SH_W-1:0] shift_eff(logic [SH_W-1:0] sh);
    return (sh < SH_W'(PAGE_MIN)) ? SH_W'(PAGE_MIN) : sh;
  endfunction

  function automatic logic [TAG_AW-1:0] ign_mask(logic [SH_W-1:0] sh);
    logic [TAG_AW-1:0] one;
    one = {{(TAG_AW-1){1'b0}}, 1'b1};
    return (one << (shift_eff(sh) - SH_W'(PAGE_MIN))) - one;
  endfunction
endpackage

// File: rtl/xlc_match.sv
module xlc_match
  import xlc_pkg::*;
#(
  parameter int N = 8
) (
  input  xlc_tag_t [N-1:0]    tags,
  input  logic [FC_W-1:0]     q_fc,
  input  logic [TAG_AW-1:0]   q_la,
  input  logic [SH_W-1:0]     q_sh,
  output logic [N-1:0]        hit
);
  logic [TAG_AW-1:0] keep_m;
  assign keep_m = ~ign_mask(q_sh);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = tags[g].v && (tags[g].fc == q_fc) &&
                    (((tags[g].la ^ q_la) & keep_m) == '0);
  end
endmodule

// File: rtl/xlc_pick.sv
module xlc_pick #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlc_victim.sv
module xlc_victim #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vld,
  input  logic [N-1:0]  hist,
  output logic [IW-1:0] idx
);
  logic [N-1:0] cand;
  logic         unused_any;

  always_comb begin
    if (~&vld) cand = ~vld;
    else       cand = vld & ~hist;
  end

  xlc_pick #(.N(N)) u_pick (.req(cand), .idx(idx), .any(unused_any));
endmodule

// File: rtl/xlc_top.sv
module xlc_top
  import xlc_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [2:0]        lk_fc,
  input  logic [31:0]       lk_addr,
  input  logic [3:0]        pg_shift,
  input  logic              ld_en,
  input  logic [2:0]        ld_fc,
  input  logic [23:0]       ld_page,
  input  logic [23:0]       ld_ppage,
  input  logic              fl_all,
  input  logic              fl_sel,
  input  logic [2:0]        fl_fc,
  input  logic [23:0]       fl_page,
  input  logic              cfg_wr,
  input  logic              cfg_keep,
  output logic              rsp_hit,
  output logic [31:0]       rsp_paddr
);
  localparam logic [ENTRIES-1:0] ONE_N = {{(ENTRIES-1){1'b0}}, 1'b1};
  localparam logic [LA_W-1:0]    ONE_A = {{(LA_W-1){1'b0}}, 1'b1};

  xlc_tag_t [ENTRIES-1:0]             tag_q, tag_d;
  logic [ENTRIES-1:0][TAG_AW-1:0]     pp_q, pp_d;
  logic [ENTRIES-1:0]                 hist_q, hist_d;
  logic                               hit_q, hit_d;
  logic [LA_W-1:0]                    pa_q, pa_d;

  logic [ENTRIES-1:0] vld_now, lk_m, ld_hm, fl_m, v1, h1, ld_m, v2;
  logic [ENTRIES-1:0] tgt_oh, tch_oh, h_upd;
  logic [IW-1:0]      lk_idx, lm_idx, vic_idx, tgt, tch_idx;
  logic               lk_any, lm_any, flush_all, touch_en, tbl_en;
  logic [LA_W-1:0]    off_m;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
    assign vld_now[g] = tag_q[g].v;
  end

  xlc_match #(.N(ENTRIES)) u_m_lk (.tags(tag_q), .q_fc(lk_fc),
    .q_la(lk_addr[LA_W-1:PAGE_MIN]), .q_sh(pg_shift), .hit(lk_m));
  xlc_match #(.N(ENTRIES)) u_m_ld (.tags(tag_q), .q_fc(ld_fc),
    .q_la(ld_page), .q_sh(pg_shift), .hit(ld_hm));
  xlc_match #(.N(ENTRIES)) u_m_fl (.tags(tag_q), .q_fc(fl_fc),
    .q_la(fl_page), .q_sh(pg_shift), .hit(fl_m));

  xlc_pick #(.N(ENTRIES)) u_pk_lk (.req(lk_m), .idx(lk_idx), .any(lk_any));
  xlc_pick #(.N(ENTRIES)) u_pk_ld (.req(ld_m), .idx(lm_idx), .any(lm_any));
  xlc_victim #(.N(ENTRIES)) u_vic (.vld(v1), .hist(h1), .idx(vic_idx));

  // Flush stage, then load stage, then history
  always_comb begin
    flush_all = fl_all | (cfg_wr & ~cfg_keep);
    if (flush_all)   v1 = '0;
    else if (fl_sel) v1 = vld_now & ~fl_m;
    else             v1 = vld_now;
    h1     = hist_q & v1;
    ld_m   = ld_hm & v1;
    tgt    = lm_any ? lm_idx : vic_idx;
    tgt_oh = ONE_N << tgt;
    v2     = ld_en ? ((v1 & ~ld_m) | tgt_oh) : v1;

    touch_en = ld_en | (lk_valid & lk_any & v1[lk_idx]);
    tch_idx  = ld_en ? tgt : lk_idx;
    tch_oh   = ONE_N << tch_idx;
    h_upd    = (h1 & v2) | tch_oh;
    if (&h_upd) h_upd = tch_oh;
    hist_d   = touch_en ? h_upd : (h1 & v2);
    tbl_en   = ld_en | flush_all | fl_sel | touch_en;

    tag_d = tag_q;
    pp_d  = pp_q;
    for (int i = 0; i < ENTRIES; i++) tag_d[i].v = v2[i];
    if (ld_en) begin
      tag_d[tgt].fc = ld_fc;
      tag_d[tgt].la = ld_page;
      pp_d[tgt]     = ld_ppage;
    end
  end

  // Registered response from the pre-update table
  always_comb begin
    off_m = (ONE_A << shift_eff(pg_shift)) - ONE_A;
    hit_d = lk_valid & lk_any;
    pa_d  = '0;
    if (hit_d)
      pa_d = ({pp_q[lk_idx], {PAGE_MIN{1'b0}}} & ~off_m) | (lk_addr & off_m);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      pp_q   <= '0;
      hist_q <= '0;
      hit_q  <= 1'b0;
      pa_q   <= '0;
    end else begin
      if (tbl_en) begin
        tag_q  <= tag_d;
        pp_q   <= pp_d;
        hist_q <= hist_d;
      end
      hit_q <= hit_d;
      pa_q  <= pa_d;
    end
  end

  assign rsp_hit   = hit_q;
  assign rsp_paddr = pa_q;

  // R1
  rsp_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> $past(lk_valid));
  // R5
  hist_never_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&hist_q));
  // R7
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !ld_en) |=> (vld_now == '0));
  // R4
  free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !lm_any && !(&v1)) |-> !v1[tgt]);
  // R6
  load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (vld_now[$past(tgt)] && $countones(vld_now) >= 1));
endmodule

// File: tb/tb_xlc_top.sv
module tb_xlc_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, ld_en, fl_all, fl_sel, cfg_wr, cfg_keep;
  logic [2:0]  lk_fc, ld_fc, fl_fc;
  logic [31:0] lk_addr;
  logic [3:0]  pg_shift;
  logic [23:0] ld_page, ld_ppage, fl_page;
  logic        rsp_hit;
  logic [31:0] rsp_paddr;

  int checks = 0, fails = 0;
  bit done = 0;

  bit          m_v[N], m_h[N];
  int unsigned m_fc[N], m_la[N], m_pp[N];
  bit          exp_hit;
  logic [31:0] exp_pa;

  always #2.5 clk = ~clk;

  xlc_top dut (.clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_fc(lk_fc),
    .lk_addr(lk_addr), .pg_shift(pg_shift), .ld_en(ld_en), .ld_fc(ld_fc),
    .ld_page(ld_page), .ld_ppage(ld_ppage), .fl_all(fl_all), .fl_sel(fl_sel),
    .fl_fc(fl_fc), .fl_page(fl_page), .cfg_wr(cfg_wr), .cfg_keep(cfg_keep),
    .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr));

  function automatic bit mt(int i, int unsigned fc, int unsigned la, int n);
    return m_v[i] && m_fc[i] == fc && (m_la[i] >> n) == (la >> n);
  endfunction

  function automatic void touch(int k);
    bit all;
    m_h[k] = 1;
    all = 1;
    for (int i = 0; i < N; i++) if (!m_h[i]) all = 0;
    if (all) begin
      for (int i = 0; i < N; i++) m_h[i] = 0;
      m_h[k] = 1;
    end
  endfunction

  function automatic void model_step();
    int sh, n, li, t;
    logic [31:0] om;
    sh = (pg_shift < 8) ? 8 : int'(pg_shift);
    n  = sh - 8;
    li = -1;
    if (lk_valid)
      for (int i = 0; i < N; i++)
        if (li < 0 && mt(i, lk_fc, lk_addr >> 8, n)) li = i;
    exp_hit = (li >= 0);
    exp_pa  = 32'h0;
    if (exp_hit) begin
      om = (32'h1 << sh) - 32'h1;
      exp_pa = ((m_pp[li] << 8) & ~om) | (lk_addr & om);
    end
    if (fl_all || (cfg_wr && !cfg_keep)) begin
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_h[i] = 0; end
    end else if (fl_sel) begin
      for (int i = 0; i < N; i++)
        if (mt(i, fl_fc, fl_page, n)) begin m_v[i] = 0; m_h[i] = 0; end
    end
    if (ld_en) begin
      t = -1;
      for (int i = 0; i < N; i++)
        if (mt(i, ld_fc, ld_page, n)) begin
          if (t < 0) t = i;
          m_v[i] = 0; m_h[i] = 0;
        end
      if (t < 0) for (int i = 0; i < N; i++) if (t < 0 && !m_v[i]) t = i;
      if (t < 0) for (int i = 0; i < N; i++) if (t < 0 && !m_h[i]) t = i;
      m_v[t] = 1; m_fc[t] = ld_fc; m_la[t] = ld_page; m_pp[t] = ld_ppage;
      touch(t);
    end else if (li >= 0 && m_v[li]) begin
      touch(li);
    end
  endfunction

  task automatic idle();
    lk_valid = 0; ld_en = 0; fl_all = 0; fl_sel = 0; cfg_wr = 0; cfg_keep = 0;
    lk_fc = 0; ld_fc = 0; fl_fc = 0; lk_addr = 0;
    ld_page = 0; ld_ppage = 0; fl_page = 0;
  endtask

  task automatic cyc(string req);
    model_step();
    @(posedge clk);
    #1;
    checks++;
    if (rsp_hit !== exp_hit || rsp_paddr !== exp_pa) begin
      fails++;
      $display("FAIL %s hit=%0b pa=%08h expected hit=%0b pa=%08h",
               req, rsp_hit, rsp_paddr, exp_hit, exp_pa);
    end
    idle();
  endtask

  task automatic look(int fc, int unsigned addr, string req);
    lk_valid = 1; lk_fc = 3'(fc); lk_addr = addr;
    cyc(req);
  endtask

  task automatic load(int fc, int unsigned pg, int unsigned pp, string req);
    ld_en = 1; ld_fc = 3'(fc); ld_page = 24'(pg); ld_ppage = 24'(pp);
    cyc(req);
  endtask

  task automatic sweep(int hi, string req);
    for (int p = 0; p <= hi; p++) look(1, (p << 12) | 32'hABC, req);
    for (int p = 20; p <= 31; p++) look(1, (p << 12) | 32'h123, req);
  endtask

  initial begin
    idle();
    pg_shift = 4'd12;
    rst_n = 0;
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_h[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rsp_hit !== 1'b0 || rsp_paddr !== 32'h0) begin
      fails++;
      $display("FAIL R1 reset hit=%0b pa=%08h expected hit=0 pa=0", rsp_hit, rsp_paddr);
    end
    rst_n = 1;
    cyc("R1");
    look(1, 32'h0000_1ABC, "R1");
    // fill every slot in order
    for (int p = 0; p < 8; p++) load(1, p << 4, 24'h100 + p, "R4");
    for (int p = 0; p < 8; p++) look(1, (p << 12) | 32'h5A5, "R2");
    look(2, 32'h0000_3000, "R2");
    // eviction by history bits
    for (int p = 8; p < 11; p++) load(1, p << 4, 24'h200 + p, "R5");
    sweep(10, "R5");
    // reload of a resident page
    load(1, 8 << 4, 24'h777, "R6");
    sweep(10, "R6");
    // selective flush then refill
    fl_sel = 1; fl_fc = 1; fl_page = 24'(9 << 4); cyc("R8");
    look(1, 32'h0000_9000, "R8");
    load(1, 20 << 4, 24'h314, "R4");
    sweep(20, "R4");
    // page size masking
    pg_shift = 4'd15;
    look(1, 32'h0000_1234, "R3");
    look(1, 32'h0001_7FFF, "R3");
    pg_shift = 4'd8;
    look(1, 32'h0000_3456, "R3");
    look(1, 32'h0000_30FF, "R3");
    pg_shift = 4'd12;
    // flush, load and lookup together
    fl_all = 1; ld_en = 1; ld_fc = 1; ld_page = 24'(30 << 4); ld_ppage = 24'h3C3;
    lk_valid = 1; lk_fc = 1; lk_addr = 32'h0000_2468;
    cyc("R9");
    look(1, 32'h0001_E010, "R9");
    look(1, 32'h0000_2468, "R9");
    // configuration writes
    load(3, 5 << 4, 24'h55, "R7");
    cfg_wr = 1; cfg_keep = 1; cyc("R7");
    look(3, 32'h0000_5001, "R7");
    cfg_wr = 1; cfg_keep = 0; cyc("R7");
    look(3, 32'h0000_5001, "R7");
    look(1, 32'h0001_E010, "R7");
    // random mix over a small page space
    for (int k = 0; k < 1500; k++) begin
      int r;
      pg_shift = 4'(12 + $urandom_range(0, 2));
      lk_valid = $urandom_range(0, 3) != 0;
      lk_fc = 3'($urandom_range(0, 1));
      lk_addr = ($urandom_range(0, 15) << 12) | $urandom_range(0, 4095);
      r = $urandom_range(0, 99);
      if (r < 35) begin
        ld_en = 1; ld_fc = 3'($urandom_range(0, 1));
        ld_page = 24'($urandom_range(0, 15) << 4); ld_ppage = 24'($urandom);
      end
      if (r >= 90 && r < 96) begin
        fl_sel = 1; fl_fc = 3'($urandom_range(0, 1));
        fl_page = 24'($urandom_range(0, 15) << 4);
      end
      if (r == 97) fl_all = 1;
      if (r >= 98) begin cfg_wr = 1; cfg_keep = $urandom_range(0, 1) != 0; end
      cyc("R5");
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule